// File: doc/BRIEF.md
# Double-Buffered Per-Channel Gamma Lookup

The block corrects a streaming RGB pixel path with a per-channel lookup. Each colour component of an incoming pixel (8 bits at the default setting) indexes its own column of a 256-entry table. The three results are reassembled into the output pixel two cycles later. The valid flag travels alongside the data with the same delay. A bypass input lets a pixel pass through unchanged, still with the same two-cycle delay.

Software fills the table through one write word. The top byte selects the entry. The lower three bytes carry the new red, green and blue values for that entry. Two copies of the table exist. With shadowing off, writes land in the copy being read, so they take effect at once. With shadowing on, writes land in the idle copy, and the copies trade places at the next frame-start strobe. A swap happens only if at least one write is waiting, which keeps a half-loaded table off the screen for the rest of a frame.

A small controller tracks the shadow mode and has three states:
- `ST_DIRECT`: shadowing off.
- `ST_ARMED`: shadowing on, nothing waiting.
- `ST_PENDING`: shadowing on, writes waiting.

Its transitions are:
- `ST_DIRECT` to `ST_ARMED` when shadowing is enabled.
- `ST_ARMED` to `ST_PENDING` on any write.
- `ST_PENDING` to `ST_ARMED` on frame start, with a swap.
- `ST_ARMED` to `ST_DIRECT` when shadowing is disabled.
- `ST_PENDING` to `ST_DIRECT` when shadowing is disabled, with an immediate swap.

Top module: `tone_curve_lut`

## Requirements
- R1: After reset both table copies hold the identity ramp (entry i returns i on every channel), and `out_valid` is 0.
- R2: A table write word carries the entry index in bits [31:24], red in [23:16], green in [15:8] and blue in [7:0]. Input pixels are packed the same way (red [23:16], green [15:8], blue [7:0]), and each output channel is looked up with its own input component.
- R3: With `shadow_en` low, a write changes the result for every pixel presented in any cycle after the write cycle.
- R4: With `shadow_en` high, a write does not affect pixel results until a `frame_start` strobe. Pixels presented after that strobe cycle see the written contents.
- R5: A `frame_start` strobe with no write since shadowing was enabled or since the last swap leaves the visible table unchanged.
- R6: `out_valid` follows `in_valid` with exactly two cycles of delay, and each result appears in that same cycle.
- R7: With `bypass` high, the pixel leaves unchanged after the same two-cycle delay, whatever the table holds.
- R8: Lowering `shadow_en` while writes are waiting makes those writes visible without a frame strobe.
- R9: After a swap, the idle copy is the table that was just replaced. An entry not rewritten before the next swap returns to that older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shadow_en | input | 1 | Route writes to the idle copy and swap at frame start |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_data | input | 32 | Index [31:24], red [23:16], green [15:8], blue [7:0] |
| bypass | input | 1 | Pass pixel through without lookup |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input pixel, red [23:16], green [15:8], blue [7:0] |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Corrected pixel, same packing |

## Verification
The bench builds the block with the default 8-bit channel width, giving 256 entries and a 32-bit write word. This setting reaches both ends of the index range, entry 0 and entry 255, as well as channels that address different entries within one pixel. A reference model of both copies and of the active-copy pointer predicts each result. That makes it possible to check the stale-entry reversion after a second swap and the immediate swap when shadowing is turned off while writes are waiting.

// File: rtl/tone_lut_pkg.sv
package tone_lut_pkg;
    typedef enum logic [1:0] {
        ST_DIRECT  = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PENDING = 2'd2
    } swap_state_e;
endpackage

// File: rtl/tone_swap_ctl.sv
module tone_swap_ctl
    import tone_lut_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shadow_en,
    input  logic frame_start,
    input  logic wr_en,
    output logic active_sel,
    output logic wr_bank
);
    swap_state_e state_q, state_d;
    logic        swap;

    // state register (also holds the active-copy pointer)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_DIRECT;
            active_sel <= 1'b0;
        end else begin
            state_q <= state_d;
            if (swap) active_sel <= ~active_sel;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DIRECT:  if (shadow_en) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!shadow_en)  state_d = ST_DIRECT;
                else if (wr_en)  state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (!shadow_en)       state_d = ST_DIRECT;
                else if (frame_start) state_d = ST_ARMED;
            end
            default: state_d = ST_DIRECT;
        endcase
    end

    // outputs
    always_comb begin
        swap    = 1'b0;
        wr_bank = ~active_sel;
        unique case (state_q)
            ST_DIRECT:  wr_bank = active_sel;
            ST_ARMED:   swap = 1'b0;
            ST_PENDING: swap = !shadow_en || frame_start;
            default:    wr_bank = active_sel;
        endcase
    end
endmodule

// File: rtl/tone_bank_store.sv
module tone_bank_store #(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [CH_W-1:0]   wr_idx,
    input  logic [3*CH_W-1:0] wr_val,
    input  logic              rd_bank,
    input  logic [CH_W-1:0]   rd_r,
    input  logic [CH_W-1:0]   rd_g,
    input  logic [CH_W-1:0]   rd_b,
    output logic [CH_W-1:0]   lut_r,
    output logic [CH_W-1:0]   lut_g,
    output logic [CH_W-1:0]   lut_b
);
    localparam int DEPTH = 1 << CH_W;
    localparam int ENT_W = 3 * CH_W;
    localparam int NBANK = 2;

    logic [CH_W-1:0] r_b [NBANK];
    logic [CH_W-1:0] g_b [NBANK];
    logic [CH_W-1:0] b_b [NBANK];

    for (genvar k = 0; k < NBANK; k++) begin : g_copy
        logic [ENT_W-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= {3{CH_W'(i)}};
            end else if (wr_en && (wr_bank == 1'(k))) begin
                mem[wr_idx] <= wr_val;
            end
        end

        assign r_b[k] = mem[rd_r][ENT_W-1 -: CH_W];
        assign g_b[k] = mem[rd_g][2*CH_W-1 -: CH_W];
        assign b_b[k] = mem[rd_b][CH_W-1:0];
    end

    assign lut_r = r_b[rd_bank];
    assign lut_g = g_b[rd_bank];
    assign lut_b = b_b[rd_bank];
endmodule

// File: rtl/tone_curve_lut.sv
module tone_curve_lut #(
    parameter  int CH_W   = 8,
    localparam int PIX_W  = 3 * CH_W,
    localparam int WORD_W = 4 * CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shadow_en,
    input  logic              frame_start,
    input  logic              tbl_wr_en,
    input  logic [WORD_W-1:0] tbl_wr_data,
    input  logic              bypass,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    logic             active_sel;
    logic             wr_bank;
    logic             s1_valid, s1_byp;
    logic [PIX_W-1:0] s1_pix;
    logic [CH_W-1:0]  lut_r, lut_g, lut_b;

    tone_swap_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .shadow_en   (shadow_en),
        .frame_start (frame_start),
        .wr_en       (tbl_wr_en),
        .active_sel  (active_sel),
        .wr_bank     (wr_bank)
    );

    tone_bank_store #(.CH_W(CH_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (tbl_wr_data[WORD_W-1 -: CH_W]),
        .wr_val  (tbl_wr_data[PIX_W-1:0]),
        .rd_bank (active_sel),
        .rd_r    (s1_pix[PIX_W-1 -: CH_W]),
        .rd_g    (s1_pix[2*CH_W-1 -: CH_W]),
        .rd_b    (s1_pix[CH_W-1:0]),
        .lut_r   (lut_r),
        .lut_g   (lut_g),
        .lut_b   (lut_b)
    );

    // stage 1: capture pixel; stage 2: registered lookup result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_byp    <= 1'b0;
            s1_pix    <= '0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_byp    <= bypass;
            s1_pix    <= in_pix;
            out_valid <= s1_valid;
            out_pix   <= s1_byp ? s1_pix : {lut_r, lut_g, lut_b};
        end
    end
endmodule

// File: rtl/tone_curve_lut_chk.sv
module tone_curve_lut_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shadow_en,
    input logic             frame_start,
    input logic             bypass,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_pix,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix,
    input logic             act_sel
);
    logic [1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r7_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen >= 2'd2) && out_valid && $past(bypass, 2)) |-> (out_pix == $past(in_pix, 2)));

    a_r4_swap_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen >= 2'd1) && (act_sel != $past(act_sel))) |-> ($past(frame_start) || !$past(shadow_en)));

    a_r5_single_swap: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen >= 2'd1) && (act_sel != $past(act_sel))) |=> $stable(act_sel));

    always_ff @(posedge clk) begin
        if (rst_n && seen == 2'd0)
            a_r1_reset_idle: assert (!out_valid);
    end
endmodule

bind tone_curve_lut tone_curve_lut_chk #(.PIX_W(PIX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shadow_en   (shadow_en),
    .frame_start (frame_start),
    .bypass      (bypass),
    .in_valid    (in_valid),
    .in_pix      (in_pix),
    .out_valid   (out_valid),
    .out_pix     (out_pix),
    .act_sel     (active_sel)
);

// File: tb/tone_curve_lut_test.sv
module tone_curve_lut_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shadow_en = 1'b0;
    logic        frame_start = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [31:0] tbl_wr_data = '0;
    logic        bypass = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic [23:0] out_pix;

    int total = 0;
    int bad = 0;

    logic [23:0] m_tbl [2][256];
    logic        m_sel = 1'b0;
    logic        m_pend = 1'b0;

    tone_curve_lut uut (
        .clk(clk), .rst_n(rst_n), .shadow_en(shadow_en), .frame_start(frame_start),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_data(tbl_wr_data), .bypass(bypass),
        .in_valid(in_valid), .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] m_look(input logic [23:0] p);
        return {m_tbl[m_sel][p[23:16]][23:16], m_tbl[m_sel][p[15:8]][15:8], m_tbl[m_sel][p[7:0]][7:0]};
    endfunction

    task automatic do_write(input logic [7:0] idx, input logic [23:0] val);
        @(negedge clk);
        tbl_wr_en = 1'b1;
        tbl_wr_data = {idx, val};
        @(negedge clk);
        tbl_wr_en = 1'b0;
        if (shadow_en) begin
            m_tbl[~m_sel][idx] = val;
            m_pend = 1'b1;
        end else begin
            m_tbl[m_sel][idx] = val;
        end
    endtask

    task automatic do_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (shadow_en && m_pend) begin
            m_sel = ~m_sel;
            m_pend = 1'b0;
        end
    endtask

    task automatic set_shadow(input logic v);
        @(negedge clk);
        shadow_en = v;
        @(negedge clk);
        if (!v && m_pend) m_sel = ~m_sel;
        m_pend = 1'b0;
    endtask

    // drive one pixel, check valid gap and result two cycles later
    task automatic send_pix(input logic [23:0] p, input logic byp, input string req);
        logic [23:0] exp;
        exp = byp ? p : m_look(p);
        @(negedge clk);
        in_valid = 1'b1;
        in_pix = p;
        bypass = byp;
        @(negedge clk);
        in_valid = 1'b0;
        bypass = 1'b0;
        chk(out_valid == 1'b0, "R6 valid early", {23'd0, out_valid}, 24'd0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R6 valid delay", {23'd0, out_valid}, 24'd1);
        chk(out_pix == exp, req, out_pix, exp);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 reset valid", {23'd0, out_valid}, 24'd0);
        send_pix(24'h123456, 1'b0, "R1 identity");
        send_pix(24'h00FFA5, 1'b0, "R1 identity ends");
    endtask

    task automatic t_direct();
        do_write(8'h10, 24'hAABBCC);
        send_pix(24'h101010, 1'b0, "R3 direct write visible");
        send_pix(24'h101110, 1'b0, "R2 per-channel index");
        do_write(8'hFF, 24'h010203);
        send_pix(24'hFFFFFF, 1'b0, "R2 top entry");
        do_write(8'h00, 24'hFE0080);
        send_pix(24'h00FF00, 1'b0, "R2 entry zero and field order");
    endtask

    task automatic t_bypass();
        send_pix(24'h10FF00, 1'b1, "R7 bypass unchanged");
    endtask

    task automatic t_shadow();
        set_shadow(1'b1);
        do_write(8'h20, 24'h010203);
        send_pix(24'h202020, 1'b0, "R4 shadow write hidden");
        do_frame();
        send_pix(24'h202020, 1'b0, "R4 visible after frame");
        chk(out_pix == 24'h010203, "R4 new entry", out_pix, 24'h010203);
    endtask

    task automatic t_no_pending();
        do_frame();
        send_pix(24'h202020, 1'b0, "R5 no swap without writes");
        chk(out_pix == 24'h010203, "R5 table kept", out_pix, 24'h010203);
    endtask

    task automatic t_stale();
        do_write(8'h21, 24'h0F0F0F);
        do_frame();
        send_pix(24'h212121, 1'b0, "R9 new entry after second swap");
        send_pix(24'h202020, 1'b0, "R9 stale entry reverts");
        chk(out_pix == 24'h202020, "R9 older value", out_pix, 24'h202020);
    endtask

    task automatic t_disable();
        do_write(8'h30, 24'h777777);
        send_pix(24'h303030, 1'b0, "R4 pending hidden");
        set_shadow(1'b0);
        send_pix(24'h303030, 1'b0, "R8 disable swaps now");
        chk(out_pix == 24'h777777, "R8 pending visible", out_pix, 24'h777777);
        do_write(8'h31, 24'h111111);
        send_pix(24'h313131, 1'b0, "R3 direct after disable");
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 256; i++)
                m_tbl[b][i] = {3{8'(i)}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_bypass();
        t_shadow();
        t_no_pending();
        t_stale();
        t_disable();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule